// File: doc/BRIEF.md
# Counter Clock, Gate and Output Routing Matrix

This block sits between a bank of three 16-bit counter/timers and an isolated digital I/O port. It decides where each counter takes its count strobe and its gate level from, and which signal reaches each digital output pin. Two byte-wide configuration registers and one word-wide output data latch are loaded through a simple register write port.

Each counter's clock is delivered as a one-cycle clock-enable strobe in the system clock domain, so no gated clocks are produced. The strobe can come from a free-running reference tick, from an input line reserved for that counter, from one input line that all three counters can share, or from the rising edge of a neighbouring counter's output. The neighbour links form a ring (2 feeds 0, 0 feeds 1, 1 feeds 2), so the counters can be cascaded into a long timebase. The top three output pins can each show either a latch bit or a counter output. Every pin is driven inverted, because a set latch bit switches on an open-collector driver that pulls the pin low.

Top module: `ctr_route_matrix`

## Requirements
- R1: After reset all three registers hold zero. Every counter then takes the reference tick as its clock, every gate is 1, `ctr_irq_pol` is 000 and `dout_pin` is 16'hFFFF.
- R2: Clock select register A (offset 2) holds counter j's clock source in bits [2j+1:2j]. The codes are: 00 reference tick; 01 its own clock line `ext_clk_in[j]`; 10 the rising output of the previous counter in the ring (counter 0 from 2, 1 from 0, 2 from 1); 11 the shared line `ext_shared_clk`. A counter gives no strobe for a source it has not selected.
- R3: A selected source gives exactly one single-cycle strobe for each rising edge. A falling edge or a level held high gives none.
- R4: Strobe latency, counted in rising clock edges after the edge that first samples the source high: the reference tick 1, a counter output 2, and an external line 3 (two synchronizer flops plus the edge register).
- R5: Bit j of select register B (offset 3) picks counter j's gate: 0 holds it at 1, and 1 follows `ext_gate_in[j]` after the two-flop synchronizer.
- R6: `dout_pin[i]` is the inverse of latch bit i. For the top three pins (i = 13 + k), bit 3+k of register B set to 1 replaces latch bit i with counter k's output, sampled through one register.
- R7: `ctr_irq_pol[0]` is bit 6 of register A, `ctr_irq_pol[1]` is bit 6 of register B and `ctr_irq_pol[2]` is bit 7 of register B.
- R8: A write with `wr_en` high loads register A from `wr_data[6:0]` at offset 2, register B from `wr_data[7:0]` at offset 3 and the latch from all of `wr_data` at offset 4, visible after that clock edge. Any other offset, or `wr_en` low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 16 | Write data; byte registers take the low bits |
| ref_tick | input | 1 | Reference clock enable, one cycle per reference period |
| ext_clk_in | input | 3 | Per-counter external clock lines (asynchronous) |
| ext_gate_in | input | 3 | Per-counter external gate lines (asynchronous) |
| ext_shared_clk | input | 1 | External clock line shared by all counters (asynchronous) |
| ctr_out | input | 3 | Raw counter outputs |
| ctr_clk_en | output | 3 | Per-counter count strobes |
| ctr_gate | output | 3 | Per-counter gate levels |
| ctr_irq_pol | output | 3 | Per-counter interrupt polarity bits |
| dout_pin | output | 16 | Inverted digital output pins |

## Verification
The bench sweeps all 64 clock-select codes against each of eight single-source rising edges. It counts strobes and records the cycle of the first one. A wrong ring direction or a swapped field then shows up as a pulse on the wrong counter, and a missing edge register shows up as a strobe held for several cycles or one fired on the falling edge. The latency check catches a synchronizer with too few or too many stages. The gate and output sweeps go through every select code against every line pattern, so a dropped inversion or a mux bit taken from the wrong field shows as a wrong pin value. Writes to unused offsets, and a write with its upper byte set, prove that the decoder leaves the neighbouring registers alone.

// File: rtl/crm_pkg.sv
package crm_pkg;

    typedef enum logic [1:0] {
        CLK_REF    = 2'b00,
        CLK_OWN    = 2'b01,
        CLK_CHAIN  = 2'b10,
        CLK_SHARED = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_SEL_A,
        TGT_SEL_B,
        TGT_LATCH
    } wr_tgt_e;

    localparam logic [3:0] OFS_SEL_A = 4'h2;
    localparam logic [3:0] OFS_SEL_B = 4'h3;
    localparam logic [3:0] OFS_LATCH = 4'h4;

    function automatic wr_tgt_e decode_offset(input logic [3:0] ofs);
        wr_tgt_e t;
        case (ofs)
            OFS_SEL_A: t = TGT_SEL_A;
            OFS_SEL_B: t = TGT_SEL_B;
            OFS_LATCH: t = TGT_LATCH;
            default:   t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/crm_regs.sv
module crm_regs
    import crm_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SEL_A_W = 7,
    parameter int SEL_B_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [SEL_A_W-1:0] sel_a,
    output logic [SEL_B_W-1:0] sel_b,
    output logic [DATA_W-1:0]  latch
);

    wr_tgt_e tgt;

    always_comb begin
        tgt = wr_en ? decode_offset(wr_addr) : TGT_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_a <= '0;
            sel_b <= '0;
            latch <= '0;
        end else begin
            unique case (tgt)
                TGT_SEL_A: sel_a <= wr_data[SEL_A_W-1:0];
                TGT_SEL_B: sel_b <= wr_data[SEL_B_W-1:0];
                TGT_LATCH: latch <= wr_data;
                TGT_NONE:  ;
            endcase
        end
    end

endmodule

// File: rtl/crm_sync.sv
module crm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_level
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d_async;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q_level = pipe[STAGES-1];

endmodule

// File: rtl/crm_rise.sv
module crm_rise #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= level;
    end

    assign rise = level & ~hist;

endmodule

// File: rtl/crm_clk_route.sv
module crm_clk_route
    import crm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     ref_tick,
    input  logic     own_rise,
    input  logic     chain_rise,
    input  logic     shared_rise,
    input  logic     gate_sel,
    input  logic     gate_level,
    output logic     clk_en,
    output logic     gate
);

    logic pick;

    always_comb begin
        unique case (src)
            CLK_REF:    pick = ref_tick;
            CLK_OWN:    pick = own_rise;
            CLK_CHAIN:  pick = chain_rise;
            CLK_SHARED: pick = shared_rise;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_en <= 1'b0;
        else        clk_en <= pick;
    end

    assign gate = gate_sel ? gate_level : 1'b1;

endmodule

// File: rtl/crm_out_mux.sv
module crm_out_mux #(
    parameter int DATA_W = 16,
    parameter int N_CTR  = 3
) (
    input  logic [DATA_W-1:0] latch,
    input  logic [N_CTR-1:0]  ctr_lvl,
    input  logic [N_CTR-1:0]  pin_sel,
    output logic [DATA_W-1:0] pin
);

    localparam int MUX_BASE = DATA_W - N_CTR;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pin
        if (i >= MUX_BASE) begin : g_shared
            assign pin[i] = ~(pin_sel[i-MUX_BASE] ? ctr_lvl[i-MUX_BASE] : latch[i]);
        end else begin : g_plain
            assign pin[i] = ~latch[i];
        end
    end

endmodule

// File: rtl/ctr_route_matrix.sv
module ctr_route_matrix
    import crm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int N_CTR      = 3,
    parameter int EXT_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ref_tick,
    input  logic [N_CTR-1:0]  ext_clk_in,
    input  logic [N_CTR-1:0]  ext_gate_in,
    input  logic              ext_shared_clk,
    input  logic [N_CTR-1:0]  ctr_out,
    output logic [N_CTR-1:0]  ctr_clk_en,
    output logic [N_CTR-1:0]  ctr_gate,
    output logic [N_CTR-1:0]  ctr_irq_pol,
    output logic [DATA_W-1:0] dout_pin
);

    localparam int SEL_A_W = 2 * N_CTR + 1;
    localparam int SEL_B_W = 3 * N_CTR - 1;

    logic [SEL_A_W-1:0] sel_a;
    logic [SEL_B_W-1:0] sel_b;
    logic [DATA_W-1:0]  latch;

    logic [N_CTR:0]     ext_clk_lvl;
    logic [N_CTR:0]     ext_clk_rise;
    logic [N_CTR-1:0]   gate_lvl;
    logic [N_CTR-1:0]   ctr_lvl;
    logic [N_CTR-1:0]   ctr_rise;

    crm_regs #(
        .DATA_W (DATA_W),
        .SEL_A_W(SEL_A_W),
        .SEL_B_W(SEL_B_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .latch  (latch)
    );

    crm_sync #(.WIDTH(N_CTR + 1), .STAGES(EXT_STAGES)) u_sync_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({ext_shared_clk, ext_clk_in}),
        .q_level(ext_clk_lvl)
    );

    crm_rise #(.WIDTH(N_CTR + 1)) u_rise_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .level(ext_clk_lvl),
        .rise (ext_clk_rise)
    );

    crm_sync #(.WIDTH(N_CTR), .STAGES(EXT_STAGES)) u_sync_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ext_gate_in),
        .q_level(gate_lvl)
    );

    crm_sync #(.WIDTH(N_CTR), .STAGES(1)) u_sync_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ctr_out),
        .q_level(ctr_lvl)
    );

    crm_rise #(.WIDTH(N_CTR)) u_rise_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .level(ctr_lvl),
        .rise (ctr_rise)
    );

    for (genvar j = 0; j < N_CTR; j++) begin : g_ctr
        localparam int CHAIN_FROM = (j + N_CTR - 1) % N_CTR;
        crm_clk_route u_route (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (clk_src_e'(sel_a[2*j +: 2])),
            .ref_tick   (ref_tick),
            .own_rise   (ext_clk_rise[j]),
            .chain_rise (ctr_rise[CHAIN_FROM]),
            .shared_rise(ext_clk_rise[N_CTR]),
            .gate_sel   (sel_b[j]),
            .gate_level (gate_lvl[j]),
            .clk_en     (ctr_clk_en[j]),
            .gate       (ctr_gate[j])
        );
    end

    assign ctr_irq_pol = {sel_b[2*N_CTR +: N_CTR-1], sel_a[2*N_CTR]};

    crm_out_mux #(.DATA_W(DATA_W), .N_CTR(N_CTR)) u_out (
        .latch  (latch),
        .ctr_lvl(ctr_lvl),
        .pin_sel(sel_b[N_CTR +: N_CTR]),
        .pin    (dout_pin)
    );

endmodule

// File: rtl/crm_checker.sv
module crm_checker #(
    parameter int DATA_W = 16,
    parameter int N_CTR  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 ref_tick,
    input logic [2*N_CTR-1:0]   sel_src,
    input logic [2*N_CTR-1:0]   sel_b_lo,
    input logic [DATA_W-1:0]    latch,
    input logic [N_CTR-1:0]     ctr_clk_en,
    input logic [N_CTR-1:0]     ctr_gate,
    input logic [DATA_W-1:0]    dout_pin
);

    localparam int MUX_BASE = DATA_W - N_CTR;

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    for (genvar j = 0; j < N_CTR; j++) begin : g_ctr_chk
        // R4: reference-tick strobe appears one edge later
        a_r4_ref_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(sel_src[2*j +: 2]) == 2'b00) |-> (ctr_clk_en[j] == $past(ref_tick)));
        // R3: edge-derived strobes never last two cycles under a stable selection
        a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && ctr_clk_en[j] && sel_src[2*j +: 2] != 2'b00 && $stable(sel_src)) |=> !ctr_clk_en[j]);
        // R5: unselected gate is held enabled
        a_r5_gate_free: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_b_lo[j] |-> ctr_gate[j]);
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_pin_chk
        if (i >= MUX_BASE) begin : g_shared
            // R6: shared pin in data mode shows the inverted latch bit
            a_r6_shared_pin: assert property (@(posedge clk) disable iff (!rst_n)
                !sel_b_lo[N_CTR + i - MUX_BASE] |-> (dout_pin[i] == ~latch[i]));
        end else begin : g_plain
            // R6: plain pin always shows the inverted latch bit
            a_r6_plain_pin: assert property (@(posedge clk) disable iff (!rst_n)
                dout_pin[i] == ~latch[i]);
        end
    end

    // R8: no register moves without a write strobe
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(wr_en)) |-> ($stable(sel_src) && $stable(sel_b_lo) && $stable(latch)));

endmodule

bind ctr_route_matrix crm_checker #(.DATA_W(DATA_W), .N_CTR(N_CTR)) u_crm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .ref_tick  (ref_tick),
    .sel_src   (sel_a[2*N_CTR-1:0]),
    .sel_b_lo  (sel_b[2*N_CTR-1:0]),
    .latch     (latch),
    .ctr_clk_en(ctr_clk_en),
    .ctr_gate  (ctr_gate),
    .dout_pin  (dout_pin)
);

// File: tb/ctr_route_matrix_bench.sv
module ctr_route_matrix_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ref_tick = 1'b0;
    logic [2:0]  ext_clk_in = '0;
    logic [2:0]  ext_gate_in = '0;
    logic        ext_shared_clk = 1'b0;
    logic [2:0]  ctr_out = '0;
    logic [2:0]  ctr_clk_en;
    logic [2:0]  ctr_gate;
    logic [2:0]  ctr_irq_pol;
    logic [15:0] dout_pin;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ctr_route_matrix u_ctr_route_matrix (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .ref_tick      (ref_tick),
        .ext_clk_in    (ext_clk_in),
        .ext_gate_in   (ext_gate_in),
        .ext_shared_clk(ext_shared_clk),
        .ctr_out       (ctr_out),
        .ctr_clk_en    (ctr_clk_en),
        .ctr_gate      (ctr_gate),
        .ctr_irq_pol   (ctr_irq_pol),
        .dout_pin      (dout_pin)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // stim: 0 ref, 1..3 own line of counter stim-1, 4 shared line, 5..7 counter stim-5 output
    function automatic bit selected(input logic [5:0] cfg, input int j, input int stim);
        logic [1:0] s;
        s = cfg[2*j +: 2];
        case (s)
            2'b00:   return stim == 0;
            2'b01:   return stim == 1 + j;
            2'b10:   return stim == 5 + ((j + 2) % 3);
            default: return stim == 4;
        endcase
    endfunction

    task automatic clk_stim(input logic [5:0] cfg, input int stim, input string tag);
        int hits [3];
        int first [3];
        int falls [3];
        int lat;
        lat = (stim == 0) ? 1 : (stim >= 5) ? 2 : 3;
        for (int j = 0; j < 3; j++) begin hits[j] = 0; first[j] = 0; falls[j] = 0; end
        @(negedge clk);
        if (stim == 0) ref_tick = 1'b1;
        else if (stim <= 3) ext_clk_in[stim-1] = 1'b1;
        else if (stim == 4) ext_shared_clk = 1'b1;
        else ctr_out[stim-5] = 1'b1;
        for (int t = 1; t <= 6; t++) begin
            @(negedge clk);
            for (int j = 0; j < 3; j++)
                if (ctr_clk_en[j]) begin
                    hits[j]++;
                    if (first[j] == 0) first[j] = t;
                end
            ref_tick = 1'b0;
        end
        ext_clk_in = '0; ext_shared_clk = 1'b0; ctr_out = '0;
        for (int t = 1; t <= 6; t++) begin
            @(negedge clk);
            for (int j = 0; j < 3; j++) if (ctr_clk_en[j]) falls[j]++;
        end
        for (int j = 0; j < 3; j++) begin
            bit m;
            m = selected(cfg, j, stim);
            chk((hits[j] > 0) == m, {tag, " R2 source select"}, hits[j], m);
            chk(hits[j] <= 1 && falls[j] == 0, {tag, " R3 single strobe, none on fall"},
                hits[j] * 16 + falls[j], m);
            if (m) chk(first[j] == lat, {tag, " R4 strobe latency"}, first[j], lat);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(dout_pin == 16'hFFFF, "R1 pins after reset", dout_pin, 16'hFFFF);
        chk(ctr_gate == 3'b111, "R1 gates after reset", ctr_gate, 3'b111);
        chk(ctr_irq_pol == 3'b000, "R1 polarity after reset", ctr_irq_pol, 0);
        chk(ctr_clk_en == 3'b000, "R1 no strobe after reset", ctr_clk_en, 0);
        clk_stim(6'd0, 0, "R1 reference default");

        // R2 R3 R4: sweep every clock-select code against every source
        for (int c = 0; c < 64; c++) begin
            wr(4'h2, 16'(c));
            for (int s = 0; s < 8; s++) clk_stim(6'(c), s, "sweep");
        end

        // R5: gate select against every line pattern
        wr(4'h2, 16'h0000);
        for (int g = 0; g < 8; g++) begin
            wr(4'h3, 16'(g));
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                ext_gate_in = 3'(p);
                repeat (3) @(negedge clk);
                for (int j = 0; j < 3; j++) begin
                    logic e;
                    e = g[j] ? p[j] : 1'b1;
                    chk(ctr_gate[j] == e, "R5 gate select", ctr_gate[j], e);
                end
            end
        end
        ext_gate_in = '0;

        // R6: output mux and inversion
        for (int m = 0; m < 8; m++) begin
            wr(4'h3, 16'(m << 3));
            for (int l = 0; l < 4; l++) begin
                logic [15:0] lv;
                lv = (l == 0) ? 16'h0000 : (l == 1) ? 16'hFFFF : (l == 2) ? 16'hA5C3 : 16'h5A3C;
                wr(4'h4, lv);
                for (int co = 0; co < 8; co++) begin
                    logic [15:0] e;
                    @(negedge clk);
                    ctr_out = 3'(co);
                    repeat (2) @(negedge clk);
                    for (int i = 0; i < 16; i++)
                        e[i] = ~((i >= 13 && m[i-13]) ? co[i-13] : lv[i]);
                    chk(dout_pin == e, "R6 output pins", dout_pin, e);
                end
                ctr_out = '0;
            end
        end

        // R7: interrupt polarity bits
        wr(4'h3, 16'h0000);
        wr(4'h2, 16'h0040);
        @(negedge clk);
        chk(ctr_irq_pol == 3'b001, "R7 polarity from A", ctr_irq_pol, 3'b001);
        wr(4'h2, 16'h0000);
        wr(4'h3, 16'h0040);
        @(negedge clk);
        chk(ctr_irq_pol == 3'b010, "R7 polarity B bit 6", ctr_irq_pol, 3'b010);
        wr(4'h3, 16'h0080);
        @(negedge clk);
        chk(ctr_irq_pol == 3'b100, "R7 polarity B bit 7", ctr_irq_pol, 3'b100);
        wr(4'h3, 16'h00C0);
        wr(4'h2, 16'h0040);
        @(negedge clk);
        chk(ctr_irq_pol == 3'b111, "R7 polarity all", ctr_irq_pol, 3'b111);

        // R8: decode, byte width and idle strobe
        wr(4'h2, 16'h0000);
        wr(4'h3, 16'h0000);
        wr(4'h4, 16'h1234);
        chk(dout_pin == ~16'h1234, "R8 latch write", dout_pin, ~16'h1234);
        for (int a = 0; a < 16; a++) begin
            if (a >= 2 && a <= 4) continue;
            wr(4'(a), 16'hFFFF);
        end
        @(negedge clk);
        wr_addr = 4'h3; wr_data = 16'h00FF;
        @(negedge clk);
        wr_addr = 4'h4; wr_data = 16'hFFFF;
        @(negedge clk);
        wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk(dout_pin == ~16'h1234, "R8 unused offsets keep latch", dout_pin, ~16'h1234);
        chk(ctr_gate == 3'b111, "R8 unused offsets keep gates", ctr_gate, 3'b111);
        chk(ctr_irq_pol == 3'b000, "R8 unused offsets keep polarity", ctr_irq_pol, 0);
        wr(4'h2, 16'hFF00);
        @(negedge clk);
        chk(ctr_irq_pol == 3'b000, "R8 byte register ignores upper byte", ctr_irq_pol, 0);
        clk_stim(6'd0, 0, "R8 clock select still reference");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule